// File: doc/BRIEF.md
# Dual-Mode Test Waveform Generator

This block produces a stream of unsigned 12-bit converter codes that describe a stimulus waveform for a device under test. Two shapes are available: a square wave and a sine wave. Each shape runs at one of two fixed output frequencies (1 Hz or 10 Hz by default). A programmable divider turns the system clock into a sample tick. Each tick emits one code together with a one-cycle valid strobe, so a downstream serializer can forward the code to an external converter.

The sine is read from a table with one entry per whole degree, 360 entries per period, centred on mid-scale and using the full code range. The sample-tick rate is switched so that this single table gives either frequency. The square wave has two samples per period: full scale for the first half-period and zero for the second.

An enable input starts and stops the output. While the block is stopped it drives code 0, issues no strobes and raises an idle indicator. A second indicator follows the present output level, so the waveform can be watched on an LED.

Top module: `wavegen_top`

## Requirements
- R1: After a synchronous active-high reset, `sample_code` is 0, `sample_vld` is 0, `idle_led` is 1 and `level_led` is 0.
- R2: With `wave_sel`=0 (square), the strobed codes alternate 4095, 0, 4095, 0, … The first strobe after a start or restart carries 4095.
- R3: With `wave_sel`=1 (sine), the strobe carrying phase index k (0 ≤ k < 360) carries round(2047.5 + 2047.5·sin(k·1°)), rounding halves upward. The code is exactly 2048 at k=0 and at k=180, 4095 at k=90 and 0 at k=270.
- R4: The sine phase index advances by one on each strobe. After index 359 it returns to 0.
- R5: The gap between strobes is CLK_HZ/(360·f) cycles for the sine and CLK_HZ/(2·f) cycles for the square. Here f is F_LO when `rate_sel`=0 and F_HI when `rate_sel`=1.
- R6: One cycle after `run_en` is seen low: `sample_code` is 0, `sample_vld` is 0 and `idle_led` is 1. These values hold for as long as `run_en` stays low.
- R7: When `run_en` goes high with a settled waveform and rate selection, the first strobe comes one full interval later (interval as in R5, counted in rising edges from the first edge that sees `run_en` high). That strobe carries phase 0.
- R8: If `wave_sel` or `rate_sel` changes while running, the phase restarts at 0. The next strobe comes one interval plus one cycle after the first edge that sees the new selection.
- R9: While running, `sample_code` changes only in a cycle where `sample_vld` is 1.
- R10: `sample_vld` is never high in two consecutive cycles.
- R11: `level_led` is 1 exactly when `sample_code` is at or above mid-scale (2048).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_sel | input | 1 | 0 = square, 1 = sine |
| rate_sel | input | 1 | 0 = low frequency (F_LO), 1 = high frequency (F_HI) |
| run_en | input | 1 | 1 = produce the waveform, 0 = stopped |
| sample_code | output | W | Current converter code, unsigned |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |
| level_led | output | 1 | Follows the output level (high half of range) |
| idle_led | output | 1 | High while output is stopped |

## Verification
The checker watches, on every cycle, the rules that relate neighbouring cycles:
- the stopped state is entered one cycle after the enable drops;
- strobes are isolated single cycles;
- the code is frozen between strobes;
- square-wave strobes carry only the two rail codes;
- the idle indicator always comes with a zero code.

The bench scenarios are the only evidence for the values and timing that depend on long histories: the exact sine code at each degree, the wrap from 359 back to 0, the strobe spacing at each frequency, and the extra cycle after a mid-run selection change. The tests run a reduced clock parameter so that full sine periods fit in the run.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    typedef enum logic {
        WAVE_SQUARE = 1'b0,
        WAVE_SINE   = 1'b1
    } wave_e;

    typedef enum logic {
        RATE_LOW  = 1'b0,
        RATE_HIGH = 1'b1
    } rate_e;

    typedef struct packed {
        wave_e wave;
        rate_e rate;
    } cfg_t;

    localparam real PI_VAL = 3.141592653589793;

    // Rounded code for table index idx of a steps-entry period,
    // centred on mid-scale and spanning the full width-bit range.
    function automatic int sine_code(input int idx, input int steps, input int width);
        real full;
        real half;
        real ang;
        full = real'((1 << width) - 1);
        half = full / 2.0;
        if (((2 * idx) % steps) == 0) begin
            return 1 << (width - 1);
        end
        ang = 2.0 * PI_VAL * real'(idx) / real'(steps);
        return $rtoi(half + half * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/wavegen_rate.sv
module wavegen_rate
    import wavegen_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int F_LO   = 1,
    parameter int F_HI   = 10,
    parameter int STEPS  = 360,
    parameter int DIV_W  = 26
) (
    input  cfg_t             cfg,
    output logic [DIV_W-1:0] term
);
    localparam int SINE_LO_T = CLK_HZ / (STEPS * F_LO);
    localparam int SINE_HI_T = CLK_HZ / (STEPS * F_HI);
    localparam int SQ_LO_T   = CLK_HZ / (2 * F_LO);
    localparam int SQ_HI_T   = CLK_HZ / (2 * F_HI);

    always_comb begin
        unique case ({cfg.wave, cfg.rate})
            {WAVE_SINE,   RATE_LOW}:  term = DIV_W'(SINE_LO_T);
            {WAVE_SINE,   RATE_HIGH}: term = DIV_W'(SINE_HI_T);
            {WAVE_SQUARE, RATE_LOW}:  term = DIV_W'(SQ_LO_T);
            default:                  term = DIV_W'(SQ_HI_T);
        endcase
    end
endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer #(
    parameter int DIV_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] term,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q + 1'b1;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q >= term - 1'b1) begin
            tick  = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wavegen_phase.sv
module wavegen_phase #(
    parameter int STEPS = 360,
    parameter int PH_W  = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            tick,
    output logic [PH_W-1:0] phase_q,
    output logic            half_q
);
    localparam logic [PH_W-1:0] LAST = PH_W'(STEPS - 1);

    logic [PH_W-1:0] phase_d;
    logic            half_d;

    always_comb begin
        phase_d = phase_q;
        half_d  = half_q;
        if (restart) begin
            phase_d = '0;
            half_d  = 1'b0;
        end else if (tick) begin
            phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
            half_d  = ~half_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            half_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            half_q  <= half_d;
        end
    end
endmodule

// File: rtl/wavegen_sine_rom.sv
module wavegen_sine_rom
    import wavegen_pkg::*;
#(
    parameter int STEPS = 360,
    parameter int W     = 12,
    parameter int PH_W  = 9
) (
    input  logic [PH_W-1:0] phase,
    output logic [W-1:0]    code
);
    logic [W-1:0] rom [STEPS];

    for (genvar i = 0; i < STEPS; i++) begin : g_rom
        assign rom[i] = W'(sine_code(i, STEPS, W));
    end

    always_comb begin
        code = '0;
        if (int'(phase) < STEPS) code = rom[phase];
    end
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
    import wavegen_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int F_LO   = 1,
    parameter int F_HI   = 10,
    parameter int STEPS  = 360,
    parameter int W      = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wave_sel,
    input  logic         rate_sel,
    input  logic         run_en,
    output logic [W-1:0] sample_code,
    output logic         sample_vld,
    output logic         level_led,
    output logic         idle_led
);
    localparam int PH_W    = $clog2(STEPS);
    localparam int SQ_LO_T = CLK_HZ / (2 * F_LO);
    localparam int DIV_W   = $clog2(SQ_LO_T + 1);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    typedef struct packed {
        cfg_t         cfg;
        logic         run;
        logic [W-1:0] code;
        logic         vld;
    } top_t;

    top_t st_d, st_q;
    cfg_t cfg_in;
    logic restart;
    logic tick;
    logic [DIV_W-1:0] term;
    logic [PH_W-1:0]  phase;
    logic             half;
    logic [W-1:0]     sine_val;
    wave_e            wave_cur;

    assign cfg_in   = '{wave: wave_e'(wave_sel), rate: rate_e'(rate_sel)};
    assign restart  = !run_en || (cfg_in != st_q.cfg);
    assign wave_cur = st_q.cfg.wave;

    wavegen_rate #(
        .CLK_HZ(CLK_HZ), .F_LO(F_LO), .F_HI(F_HI), .STEPS(STEPS), .DIV_W(DIV_W)
    ) u_rate (
        .cfg (st_q.cfg),
        .term(term)
    );

    wavegen_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .term   (term),
        .tick   (tick)
    );

    wavegen_phase #(.STEPS(STEPS), .PH_W(PH_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (tick),
        .phase_q(phase),
        .half_q (half)
    );

    wavegen_sine_rom #(.STEPS(STEPS), .W(W), .PH_W(PH_W)) u_rom (
        .phase(phase),
        .code (sine_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_in;
        st_d.run = run_en;
        st_d.vld = tick;
        if (!run_en) begin
            st_d.code = '0;
        end else if (tick) begin
            if (st_q.cfg.wave == WAVE_SINE) st_d.code = sine_val;
            else                            st_d.code = half ? '0 : FULL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cfg: '{wave: WAVE_SQUARE, rate: RATE_LOW},
                      run: 1'b0, code: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_code = st_q.code;
    assign sample_vld  = st_q.vld;
    assign level_led   = st_q.code[W-1];
    assign idle_led    = !st_q.run;
endmodule

// File: rtl/wavegen_chk.sv
module wavegen_chk
    import wavegen_pkg::*;
#(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input wave_e        wave_cur,
    input logic [W-1:0] sample_code,
    input logic         sample_vld,
    input logic         idle_led
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sample_vld && sample_code == '0 && idle_led));

    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!sample_vld && sample_code == '0 && idle_led));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        idle_led |-> (sample_code == '0 && !sample_vld));

    p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> !sample_vld);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!sample_vld && !idle_led && !$past(idle_led)) |-> $stable(sample_code));

    p_square_rails_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && wave_cur == WAVE_SQUARE) |->
            (sample_code == '0 || sample_code == {W{1'b1}}));
endmodule

bind wavegen_top wavegen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .wave_cur   (wave_cur),
    .sample_code(sample_code),
    .sample_vld (sample_vld),
    .idle_led   (idle_led)
);

// File: tb/sim_wavegen_top.sv
module sim_wavegen_top;
    localparam int CLK_HZ = 7200;
    localparam int W      = 12;
    // columns: wave_sel, rate_sel, interval, samples
    localparam int NV = 4;
    localparam int VEC [NV][4] = '{
        '{1, 1, 2,    370},
        '{1, 0, 20,   40},
        '{0, 1, 360,  4},
        '{0, 0, 3600, 3}
    };

    logic clk = 1'b0;
    logic rst, wave_sel, rate_sel, run_en;
    logic [W-1:0] sample_code;
    logic sample_vld, level_led, idle_led;
    int checks = 0;
    int fails  = 0;
    int hold_bad;

    always #5 clk = ~clk;

    wavegen_top #(.CLK_HZ(CLK_HZ), .F_LO(1), .F_HI(10), .STEPS(360), .W(W)) u0 (
        .clk(clk), .rst(rst), .wave_sel(wave_sel), .rate_sel(rate_sel),
        .run_en(run_en), .sample_code(sample_code), .sample_vld(sample_vld),
        .level_led(level_led), .idle_led(idle_led)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sine_exp(input int k);
        real r;
        r = 2047.5 + 2047.5 * $sin(real'(k) * 4.0 * $atan(1.0) / 180.0);
        return $rtoi($floor(r + 0.5));
    endfunction

    // Counts falling edges until a strobe is seen; flags code changes in between.
    task automatic wait_vld(output int n);
        logic [W-1:0] start_code;
        start_code = sample_code;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!sample_vld && !idle_led && sample_code != start_code) hold_bad++;
        end while (!sample_vld && n < 5000);
    endtask

    task automatic start_cfg(input int w, input int r);
        @(negedge clk);
        run_en = 1'b0;
        wave_sel = w[0];
        rate_sel = r[0];
        repeat (2) @(negedge clk);
        run_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int expc;
        rst = 1'b1; wave_sel = 1'b0; rate_sel = 1'b0; run_en = 1'b0;
        repeat (3) @(negedge clk);
        check(sample_code == 0, "R1 code", int'(sample_code), 0);
        check(!sample_vld && idle_led, "R1 vld/idle", {sample_vld, idle_led}, 1);
        check(!level_led, "R1 level", int'(level_led), 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R7 R11
        for (int v = 0; v < NV; v++) begin
            hold_bad = 0;
            start_cfg(VEC[v][0], VEC[v][1]);
            for (int i = 0; i < VEC[v][3]; i++) begin
                wait_vld(n);
                check(n == VEC[v][2], (i == 0) ? "R7 first strobe" : "R5 interval", n, VEC[v][2]);
                if (VEC[v][0] == 1) begin
                    expc = sine_exp(i % 360);
                    check(int'(sample_code) == expc, (i >= 360) ? "R4 wrap" : "R3 sine code",
                          int'(sample_code), expc);
                end else begin
                    expc = (i % 2 == 0) ? 4095 : 0;
                    check(int'(sample_code) == expc, "R2 square code", int'(sample_code), expc);
                end
                check(level_led == (expc >= 2048), "R11 level", int'(level_led), int'(expc >= 2048));
            end
            @(negedge clk);
            check(!sample_vld, "R10 strobe width", int'(sample_vld), 0);
            check(hold_bad == 0, "R9 hold between strobes", hold_bad, 0);
        end

        // R3 fixed points
        check(sine_exp(90) == 4095 && sine_exp(270) == 0 && sine_exp(180) == 2048,
              "R3 table anchors", sine_exp(180), 2048);

        // R6 stop while running sine
        start_cfg(1, 1);
        repeat (3) wait_vld(n);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(sample_code == 0 && idle_led, "R6 stop code/idle", int'(sample_code), 0);
        n = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (sample_vld || sample_code != 0 || !idle_led) n++;
        end
        check(n == 0, "R6 stays stopped", n, 0);

        // R8 restart on rate change (sine low -> high)
        start_cfg(1, 0);
        repeat (6) wait_vld(n);
        @(negedge clk);
        rate_sel = 1'b1;
        wait_vld(n);
        check(n == 3, "R8 restart delay rate", n, 3);
        check(int'(sample_code) == 2048, "R8 restart phase 0", int'(sample_code), 2048);
        wait_vld(n);
        check(n == 2 && int'(sample_code) == sine_exp(1), "R8 next phase", int'(sample_code), sine_exp(1));

        // R8 restart on waveform change (sine high -> square high)
        @(negedge clk);
        wave_sel = 1'b0;
        wait_vld(n);
        check(n == 361, "R8 restart delay wave", n, 361);
        check(int'(sample_code) == 4095, "R8 square first half", int'(sample_code), 4095);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule